// File: doc/BRIEF.md
# Slot Attention Indicator Controller

This block is the attention-indicator slice of the slot control logic on a PCI Express downstream port. Software programs it through a small register write port. One register holds the capability bit that says an attention indicator is fitted. A control register holds a 2-bit indicator command and two interrupt enables. A status register holds a command-completed flag, which software clears by writing 1 to it.

A write of a real command (any code but the reserved 00b) does three things. It updates the indicator state. In the next cycle it emits a one-cycle message strobe toward the downstream device, with the new state alongside. One cycle after that strobe it marks the command as completed. The completion raises an interrupt request if the capability bit and both enables are all set at that moment. The request is routed to either the MSI request line or the INTx request line, chosen by a mode input, and stays up until software clears the status flag. The active-low LED output shows the indicator state as on, off or blinking at a divided rate. The LED is forced off whenever the capability bit is clear.

Top module: `atn_ind_ctrl`

## Requirements
- R1: After reset, `atn_led_n` is 1, `ind_msg_vld` is 0, `ind_msg_state` is 11b (off), `cmd_done` is 0, both interrupt lines are 0, and the capability bit and both enables are 0.
- R2: A write with `wr_sel`=0 stores `wr_data[3]` as the indicator-present bit. While that bit is 0, `atn_led_n` is 1.
- R3: A write with `wr_sel`=1 stores `wr_data[7:6]` as the indicator command when that field is not 00b. With the indicator present, code 01b drives `atn_led_n` low (on) and code 11b drives it high (off).
- R4: A control write with a non-00b field makes `ind_msg_vld` 1 for exactly the one cycle after the write edge. In that cycle `ind_msg_state` shows the new code.
- R5: `cmd_done` becomes 1 in the cycle after the strobe cycle. It returns to 0 after a write with `wr_sel`=2 and `wr_data[4]`=1. A completion landing on the same edge as a clear wins.
- R6: A control write whose field is 00b leaves `ind_msg_state` and the LED unchanged, emits no strobe and sets no completion. Its enable bits (`wr_data[4]` command-completed interrupt enable, `wr_data[5]` hot-plug interrupt enable) are still stored.
- R7: The interrupt request rises together with `cmd_done` only if the present bit, bit 4 and bit 5 are all 1 at the completion edge. It stays up until `cmd_done` is cleared, and later changes to those three bits neither raise it nor drop it.
- R8: When `irq_mode` is 1 the request appears on `irq_msi`; when it is 0 it appears on `irq_intx`. The two lines are never 1 together.
- R9: After a write of code 10b (blink), `atn_led_n` is low for `BLINK_DIV` cycles, then high for `BLINK_DIV` cycles, and keeps alternating.
- R10: A write with `wr_sel`=3 changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 capability, 1 control, 2 status, 3 unused |
| wr_data | input | REG_W | Write data |
| irq_mode | input | 1 | 1 selects MSI request line, 0 selects INTx |
| atn_led_n | output | 1 | Attention LED drive, active low |
| ind_msg_vld | output | 1 | One-cycle indicator message strobe |
| ind_msg_state | output | 2 | Indicator code carried with the message |
| cmd_done | output | 1 | Command-completed status flag |
| irq_msi | output | 1 | Interrupt request, MSI path |
| irq_intx | output | 1 | Interrupt request, INTx path |

## Verification
A corrupted indicator code shows up on `ind_msg_state` and on the LED in the very next sampled cycle. A slip in the blink divider shows as an LED edge that arrives one or more cycles early or late, within a single blink period. A lost or stuck message register shows two cycles after the write, either as a missing strobe or as a `cmd_done` flag that never rises or rises uninvited. A wrongly held interrupt register shows on the selected request line on the clear edge, or on the completion edge when the gates are closed.

// File: rtl/atn_ind_pkg.sv
package atn_ind_pkg;
   typedef enum logic [1:0] {
      SEL_CAP  = 2'd0,
      SEL_CTRL = 2'd1,
      SEL_STAT = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   typedef enum logic [1:0] {
      IND_RSVD  = 2'b00,
      IND_ON    = 2'b01,
      IND_BLINK = 2'b10,
      IND_OFF   = 2'b11
   } ind_code_e;

   localparam int CAP_PRESENT_BIT = 3;
   localparam int CTRL_CODE_LSB   = 6;
   localparam int CTRL_CCIE_BIT   = 4;
   localparam int CTRL_HPIE_BIT   = 5;
   localparam int STAT_DONE_BIT   = 4;
   localparam int MIN_REG_W       = 8;
endpackage

// File: rtl/atn_regs.sv
module atn_regs
   import atn_ind_pkg::*;
#(
   parameter int REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [REG_W-1:0] wr_data,
   output logic             present,
   output logic             ccie,
   output logic             hpie,
   output ind_code_e        code,
   output logic             cmd_go,
   output logic             blink_go,
   output logic             stat_clr
);
   logic      cap_wr, ctrl_wr;
   ind_code_e new_code;

   assign cap_wr   = wr_en && (reg_sel_e'(wr_sel) == SEL_CAP);
   assign ctrl_wr  = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL);
   assign new_code = ind_code_e'(wr_data[CTRL_CODE_LSB +: 2]);
   assign cmd_go   = ctrl_wr && (new_code != IND_RSVD);
   assign blink_go = cmd_go && (new_code == IND_BLINK);
   assign stat_clr = wr_en && (reg_sel_e'(wr_sel) == SEL_STAT) && wr_data[STAT_DONE_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         present <= 1'b0;
         ccie    <= 1'b0;
         hpie    <= 1'b0;
         code    <= IND_OFF;
      end else begin
         if (cap_wr) present <= wr_data[CAP_PRESENT_BIT];
         if (ctrl_wr) begin
            ccie <= wr_data[CTRL_CCIE_BIT];
            hpie <= wr_data[CTRL_HPIE_BIT];
         end
         if (cmd_go) code <= new_code;
      end
   end

   assert_rsvd_keeps_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && wr_data[CTRL_CODE_LSB +: 2] == 2'b00) |=> $stable(code));
   assert_no_rsvd_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
      code != IND_RSVD);
endmodule

// File: rtl/atn_blink.sv
module atn_blink #(
   parameter int BLINK_DIV = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic phase
);
   localparam int CNT_W = (BLINK_DIV > 1) ? $clog2(BLINK_DIV) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BLINK_DIV - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         phase <= 1'b0;
      end else if (restart) begin
         cnt   <= '0;
         phase <= 1'b0;
      end else if (cnt == LAST) begin
         cnt   <= '0;
         phase <= ~phase;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assert_restart_on_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (!phase && cnt == '0));
   assert_phase_flip_at_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && cnt == LAST) |=> (phase != $past(phase)));
endmodule

// File: rtl/atn_cmpl.sv
module atn_cmpl (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_go,
   input  logic stat_clr,
   input  logic gate_ok,
   input  logic irq_mode,
   output logic msg_vld,
   output logic done,
   output logic irq_msi,
   output logic irq_intx
);
   logic irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msg_vld <= 1'b0;
         done    <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         msg_vld <= cmd_go;
         if (msg_vld)       done <= 1'b1;
         else if (stat_clr) done <= 1'b0;
         if (msg_vld && gate_ok) irq_q <= 1'b1;
         else if (stat_clr)      irq_q <= 1'b0;
      end
   end

   assign irq_msi  = irq_q && irq_mode;
   assign irq_intx = irq_q && !irq_mode;

   assert_done_follows_msg_R5: assert property (@(posedge clk) disable iff (!rst_n)
      msg_vld |=> done);
   assert_msg_follows_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_go |=> msg_vld);
   assert_irq_needs_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> done);
   assert_irq_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({irq_msi, irq_intx}));
endmodule

// File: rtl/atn_ind_ctrl.sv
module atn_ind_ctrl
   import atn_ind_pkg::*;
#(
   parameter int REG_W     = 8,
   parameter int BLINK_DIV = 8,
   parameter bit LED_REG   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [REG_W-1:0] wr_data,
   input  logic             irq_mode,
   output logic             atn_led_n,
   output logic             ind_msg_vld,
   output logic [1:0]       ind_msg_state,
   output logic             cmd_done,
   output logic             irq_msi,
   output logic             irq_intx
);
   generate
      if (REG_W < MIN_REG_W) begin : g_bad_reg_w
         $error("atn_ind_ctrl: REG_W must be at least 8");
      end
      if (BLINK_DIV < 2) begin : g_bad_div
         $error("atn_ind_ctrl: BLINK_DIV must be at least 2");
      end
   endgenerate

   logic      present, ccie, hpie, cmd_go, blink_go, stat_clr, phase;
   logic      led_n_next;
   ind_code_e code;

   atn_regs #(.REG_W(REG_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .present(present), .ccie(ccie), .hpie(hpie), .code(code),
      .cmd_go(cmd_go), .blink_go(blink_go), .stat_clr(stat_clr)
   );

   atn_blink #(.BLINK_DIV(BLINK_DIV)) u_blink (
      .clk(clk), .rst_n(rst_n), .restart(blink_go), .phase(phase)
   );

   atn_cmpl u_cmpl (
      .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .stat_clr(stat_clr),
      .gate_ok(present && ccie && hpie), .irq_mode(irq_mode),
      .msg_vld(ind_msg_vld), .done(cmd_done), .irq_msi(irq_msi), .irq_intx(irq_intx)
   );

   always_comb begin
      if (!present) begin
         led_n_next = 1'b1;
      end else begin
         unique case (code)
            IND_ON:    led_n_next = 1'b0;
            IND_BLINK: led_n_next = phase;
            default:   led_n_next = 1'b1;
         endcase
      end
   end

   generate
      if (LED_REG) begin : g_led_flop
         logic led_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) led_q <= 1'b1;
            else        led_q <= led_n_next;
         end
         assign atn_led_n = led_q;
         assert_led_off_absent_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !present |=> atn_led_n);
      end else begin : g_led_comb
         assign atn_led_n = led_n_next;
         assert_led_off_absent_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !present |-> atn_led_n);
      end
   endgenerate

   assign ind_msg_state = code;
endmodule

// File: tb/atn_ind_ctrl_bench.sv
module atn_ind_ctrl_bench;
   localparam int REG_W = 8;
   localparam int DIV   = 8;
   localparam bit LREG  = 1'b0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [1:0] wr_sel = 2'd3;
   logic [REG_W-1:0] wr_data = '0;
   logic irq_mode = 1'b1;
   logic atn_led_n, ind_msg_vld, cmd_done, irq_msi, irq_intx;
   logic [1:0] ind_msg_state;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   atn_ind_ctrl #(.REG_W(REG_W), .BLINK_DIV(DIV), .LED_REG(LREG)) u_atn_ind_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .irq_mode(irq_mode), .atn_led_n(atn_led_n), .ind_msg_vld(ind_msg_vld),
      .ind_msg_state(ind_msg_state), .cmd_done(cmd_done), .irq_msi(irq_msi), .irq_intx(irq_intx)
   );

   // reference model state
   bit m_present, m_ccie, m_hpie, m_msg, m_done, m_irq, m_phase, m_led_q;
   bit [1:0] m_code;
   int m_cnt;

   function automatic bit f_led(bit present, bit [1:0] code, bit phase);
      if (!present) return 1'b1;
      if (code == 2'b01) return 1'b0;
      if (code == 2'b10) return phase;
      return 1'b1;
   endfunction

   function automatic string f_led_tag(bit present, bit [1:0] code);
      if (!present) return "R2";
      if (code == 2'b10) return "R9";
      return "R3";
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_present = 0; m_ccie = 0; m_hpie = 0; m_msg = 0; m_done = 0; m_irq = 0;
         m_phase = 0; m_cnt = 0; m_code = 2'b11; m_led_q = 1;
      end else begin
         bit go, clr, gate;
         go   = wr_en && wr_sel == 2'd1 && wr_data[7:6] != 2'b00;
         clr  = wr_en && wr_sel == 2'd2 && wr_data[4];
         gate = m_present && m_ccie && m_hpie;
         m_led_q = f_led(m_present, m_code, m_phase);
         if (m_msg) m_done = 1; else if (clr) m_done = 0;
         if (m_msg && gate) m_irq = 1; else if (clr) m_irq = 0;
         if (go && wr_data[7:6] == 2'b10) begin m_cnt = 0; m_phase = 0; end
         else if (m_cnt == DIV - 1) begin m_cnt = 0; m_phase = !m_phase; end
         else m_cnt++;
         m_msg = go;
         if (wr_en && wr_sel == 2'd0) m_present = wr_data[3];
         if (wr_en && wr_sel == 2'd1) begin m_ccie = wr_data[4]; m_hpie = wr_data[5]; end
         if (go) m_code = wr_data[7:6];
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(f_led_tag(m_present, m_code), atn_led_n,
             LREG ? m_led_q : f_led(m_present, m_code, m_phase));
         chk("R4 strobe", ind_msg_vld, m_msg);
         chk("R4 state", ind_msg_state, m_code);
         chk("R5 done", cmd_done, m_done);
         chk("R7/R8 msi", irq_msi, m_irq && irq_mode);
         chk("R7/R8 intx", irq_intx, m_irq && !irq_mode);
      end
   end

   task automatic step();
      @(posedge clk); #2;
   endtask

   task automatic wr(logic [1:0] sel, logic [7:0] data);
      wr_en = 1; wr_sel = sel; wr_data = data;
      step();
      wr_en = 0; wr_sel = 2'd3;
   endtask

   task automatic summary();
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) step();
      rst_n = 1;
      step();
      // R1 reset state
      chk("R1 led", atn_led_n, 1); chk("R1 msg", ind_msg_vld, 0);
      chk("R1 state", ind_msg_state, 2'b11); chk("R1 done", cmd_done, 0);
      chk("R1 irq", {irq_msi, irq_intx}, 0);
      // R2 present bit, R3 on command with both enables
      wr(2'd0, 8'h08);
      irq_mode = 1;
      wr(2'd1, 8'h70);
      chk("R4 strobe after on", ind_msg_vld, 1);
      chk("R3 led on", atn_led_n, 0);
      step();
      chk("R4 strobe single", ind_msg_vld, 0);
      chk("R5 done set", cmd_done, 1);
      chk("R7 msi raised", irq_msi, 1);
      // R6 reserved write closes enables, leaves code
      wr(2'd1, 8'h00);
      chk("R6 no strobe", ind_msg_vld, 0);
      chk("R6 code kept", ind_msg_state, 2'b01);
      chk("R6 led kept", atn_led_n, 0);
      step();
      chk("R7 held after gate close", irq_msi, 1);
      irq_mode = 0; #1;
      chk("R8 intx path", {irq_msi, irq_intx}, 2'b01);
      // R5 clear
      wr(2'd2, 8'h10);
      chk("R5 cleared", cmd_done, 0);
      chk("R7 dropped", irq_intx, 0);
      // R7 closed gates: completion raises no request
      wr(2'd1, 8'hC0);
      step();
      chk("R7 gated done", cmd_done, 1);
      chk("R7 gated irq", {irq_msi, irq_intx}, 0);
      wr(2'd2, 8'h10);
      // R9 blink timing
      wr(2'd1, 8'hB0);
      for (int i = 0; i < DIV; i++) begin
         chk("R9 blink low", atn_led_n, 0); step();
      end
      for (int i = 0; i < DIV; i++) begin
         chk("R9 blink high", atn_led_n, 1); step();
      end
      chk("R9 blink low again", atn_led_n, 0);
      // R10 unused select
      wr(2'd3, 8'hFF);
      chk("R10 no strobe", ind_msg_vld, 0);
      chk("R10 code kept", ind_msg_state, 2'b10);
      // R2 absent indicator
      wr(2'd0, 8'h00);
      chk("R2 led off", atn_led_n, 1);
      wr(2'd1, 8'h40);
      chk("R2 led off on-cmd", atn_led_n, 1);
      // constrained random
      for (int n = 0; n < 4000; n++) begin
         int r;
         r = $urandom_range(0, 99);
         irq_mode = ($urandom_range(0, 15) == 0) ? !irq_mode : irq_mode;
         if (r < 55) begin
            step();
         end else begin
            logic [7:0] d;
            d = 8'($urandom);
            if (r < 62) wr(2'd0, d);
            else if (r < 85) wr(2'd1, d);
            else if (r < 97) wr(2'd2, d);
            else wr(2'd3, d);
         end
      end
      step();
      summary();
   end
endmodule